// File: doc/BRIEF.md
# Double-Buffered Compare PWM Timer

This block is an 8-bit timer that produces a pulse-width-modulated waveform from two compare values. One value, the period limit, ends every period: when the running count meets it on a prescaler tick, the count is reloaded with FCh, the output register takes a programmable "period level", and a period flag is raised. The other value, the edge point, marks where the waveform changes inside the period: when the count meets it, the output register takes a programmable "edge level". With edge level 1 and period level 0, the high time in ticks equals the period limit minus the edge point. The period is ((limit - FCh) mod 256) + 1 ticks.

Software programs the block through a write-only port. Address 0 is the control byte, address 1 the edge-point shadow, address 2 the period-limit shadow, and address 3 clears the flag. While the waveform runs, shadow writes wait in their registers. They are copied into the active compare registers only at the next period-limit match, so a period is never cut short or stretched by a half-updated pair. A 2-bit clock-select field picks how many clock cycles make up one counter tick.

A two-state controller governs the block. ST_OFF is the idle state: the counter is held at FCh, the output register is low, and the active compares follow the shadows. ST_RUN is the waveform state. The transition GO (ST_OFF to ST_RUN) fires when the mode-enable bit is set, whatever the one-pulse bit holds. The transition STOP (ST_RUN to ST_OFF) fires when the mode-enable bit is cleared.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset, pwm_out, period_flag and irq are low and the block is in ST_OFF, with all compare registers at zero.
- R2: In ST_RUN, the count advances by one on each prescaler tick and wraps from FFh to 00h. On a tick where it equals the active period limit (shadowed at address 2), it reloads to FCh. The period therefore lasts ((limit - FCh) mod 256) + 1 ticks.
- R3: On a tick in ST_RUN, a period-limit match drives the output register to the period level (control bit 4). Otherwise, an edge-point match (shadowed at address 1) drives it to the edge level (control bit 3). When both match on the same tick, the period-limit match wins. With edge level 1 and period level 0, the high time is (limit - edge) mod 256 ticks.
- R4: When the edge level equals the period level, the output stays at that level from the first match onward.
- R5: In ST_RUN, values written to addresses 1 and 2 take effect only at the next period-limit match; the running period keeps the old values. In ST_OFF, the active values follow the shadows.
- R6: Clock-select (control bits 6:5) values 0, 1, 2 and 3 give one counter tick every 2, 4, 8 and 8000 clock cycles.
- R7: period_flag is set at every period-limit match in ST_RUN. A write to address 3 with data bit 0 set clears it. If the set and the clear fall in the same cycle, the set wins.
- R8: irq is high exactly when period_flag is high, the interrupt-enable bit (control bit 7) is set, and glob_mask is low.
- R9: Control bit 0 (mode enable) selects ST_RUN whether or not control bit 1 (one-pulse) is set. Bit 1 alone leaves the block in ST_OFF: the output stays low and the flag is not set.
- R10: pwm_out shows the output register only while the output-enable bit (control bit 2) is set. Otherwise pwm_out is low, even while the waveform runs.
- R11: In ST_OFF the count is held at FCh and the output register is low, so the first period after GO starts from FCh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 edge point, 2 period limit, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| glob_mask | input | 1 | Global interrupt mask; high blocks irq |
| pwm_out | output | 1 | Waveform pin |
| period_flag | output | 1 | Period-end status flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle: the flag-set caused by a period-limit match and the software clear write to address 3. A second collision is an edge-point match and a period-limit match on the same tick. For the first, the bench finds a falling edge of the waveform (a period end). It counts exactly one period of clock cycles and drives the clear write so that it lands on the next period-end edge; it expects the flag to remain set. For the second, it programs the edge point equal to the period limit and expects the pin to stay at the period level for several periods.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EDGE   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 2'd3;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic       irq_en;    // bit 7
        logic [1:0] clk_sel;   // bits 6:5
        logic       lvl_per;   // bit 4
        logic       lvl_edge;  // bit 3
        logic       out_en;    // bit 2
        logic       opm_en;    // bit 1
        logic       pwm_en;    // bit 0
    } ctrl_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV0 = 2,
    parameter int DIV1 = 4,
    parameter int DIV2 = 8,
    parameter int DIV3 = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = $clog2(DIV3) + 1;
    localparam logic [PW-1:0] LIM0 = PW'(DIV0 - 1);
    localparam logic [PW-1:0] LIM1 = PW'(DIV1 - 1);
    localparam logic [PW-1:0] LIM2 = PW'(DIV2 - 1);
    localparam logic [PW-1:0] LIM3 = PW'(DIV3 - 1);

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        unique case (sel)
            2'd0:    lim = LIM0;
            2'd1:    lim = LIM1;
            2'd2:    lim = LIM2;
            default: lim = LIM3;
        endcase
    end

    // A count already past a newly selected limit ends at once.
    assign tick = (pcnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt_q <= '0;
        else if (tick) pcnt_q <= '0;
        else           pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  edge_sh,
    output logic [CNT_W-1:0]  per_sh,
    output logic              clr_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            edge_sh <= '0;
            per_sh  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL:   ctrl_q  <= ctrl_t'(wr_data[7:0]);
                ADR_EDGE:   edge_sh <= wr_data;
                ADR_PERIOD: per_sh  <= wr_data;
                default:    ;
            endcase
        end
    end

    assign clr_req = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int RELOAD = 252,
    parameter int DIV0   = 2,
    parameter int DIV1   = 4,
    parameter int DIV2   = 8,
    parameter int DIV3   = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              glob_mask,
    output logic              pwm_out,
    output logic              period_flag,
    output logic              irq
);
    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] edge_sh, per_sh;
    logic             clr_req;
    logic             tick;

    tmr_state_e       state_q, state_d;
    logic             run_req;
    logic [CNT_W-1:0] cnt_q, act_edge, act_per;
    logic             out_q, flag_q;
    logic             per_hit, edge_hit;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .edge_sh (edge_sh),
        .per_sh  (per_sh),
        .clr_req (clr_req)
    );

    pwm_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q.clk_sel),
        .tick  (tick)
    );

    // Mode decode: the waveform mode outranks the one-pulse request.
    always_comb begin
        run_req = 1'b0;
        unique casez ({ctrl_q.pwm_en, ctrl_q.opm_en})
            2'b1?:   run_req = 1'b1;
            2'b01:   run_req = 1'b0;
            default: run_req = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (run_req)  state_d = ST_RUN;   // GO
            ST_RUN: if (!run_req) state_d = ST_OFF;   // STOP
            default:              state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign per_hit  = tick && (cnt_q == act_per);
    assign edge_hit = tick && (cnt_q == act_edge);

    // Counter and active compare pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_edge <= '0;
            act_per  <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_q    <= RELOAD_V;
                    act_edge <= edge_sh;
                    act_per  <= per_sh;
                end
                ST_RUN: begin
                    if (per_hit) begin
                        cnt_q    <= RELOAD_V;
                        act_edge <= edge_sh;
                        act_per  <= per_sh;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= RELOAD_V;
            endcase
        end
    end

    // Output register and period flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    out_q <= 1'b0;
                    if (clr_req) flag_q <= 1'b0;
                end
                ST_RUN: begin
                    if (per_hit)       out_q <= ctrl_q.lvl_per;
                    else if (edge_hit) out_q <= ctrl_q.lvl_edge;
                    if (per_hit)       flag_q <= 1'b1;
                    else if (clr_req)  flag_q <= 1'b0;
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign pwm_out     = out_q & ctrl_q.out_en;
    assign period_flag = flag_q;
    assign irq         = flag_q & ctrl_q.irq_en & ~glob_mask;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int RELOAD = 252
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       state,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_edge,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] edge_sh,
    input logic [CNT_W-1:0] per_sh,
    input logic             out_q,
    input logic             flag,
    input logic             irq,
    input logic             pwm_en
);
    localparam logic [CNT_W-1:0] RV = CNT_W'(RELOAD);

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && $past(state) == ST_OFF && $past(rst_n)) |-> (cnt == RV && !out_q));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && cnt == act_per) |=> (cnt == RV));

    // R5
    shadow_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && cnt == act_per) |=>
            (act_edge == $past(edge_sh) && act_per == $past(per_sh)));

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(tick && cnt == act_per)) |=>
            ($stable(act_edge) && $stable(act_per)));

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(state == ST_RUN && tick && cnt == act_per));

    // R9
    mode_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> (state == ST_RUN));

    // R9
    mode_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> (state == ST_OFF));

    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind cmp_pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .tick     (tick),
    .cnt      (cnt_q),
    .act_edge (act_edge),
    .act_per  (act_per),
    .edge_sh  (edge_sh),
    .per_sh   (per_sh),
    .out_q    (out_q),
    .flag     (flag_q),
    .irq      (irq),
    .pwm_en   (ctrl_q.pwm_en)
);

// File: tb/cmp_pwm_timer_test.sv
`timescale 1ns/1ps
module cmp_pwm_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       glob_mask = 1'b0;
    logic       pwm_out, period_flag, irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    cmp_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .glob_mask(glob_mask), .pwm_out(pwm_out),
        .period_flag(period_flag), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d cycles, expected below 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit pwm, input bit opm, input bit oe,
                                       input bit le, input bit lp, input int sel, input bit ie);
        return {ie, 2'(sel), lp, le, oe, opm, pwm};
    endfunction

    function automatic int div_of(input int sel);
        case (sel)
            0: return 2;
            1: return 4;
            2: return 8;
            default: return 8000;
        endcase
    endfunction

    task automatic wait_edge(input logic to_val);
        logic p;
        @(negedge clk);
        p = pwm_out;
        forever begin
            @(negedge clk);
            if (p != to_val && pwm_out == to_val) return;
            p = pwm_out;
        end
    endtask

    task automatic meas_run(input logic lv, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (pwm_out != lv) return;
            n++;
        end
    endtask

    // Start a fresh waveform from ST_OFF and measure one full period.
    task automatic run_cfg(input string req, input int e, input int p, input int sel, input bit opm);
        int hi, lo, d, t;
        d = div_of(sel);
        t = ((p - 252) & 255) + 1;
        wr(2'd0, ctl(0, 0, 1, 1, 0, sel, 0));
        wr(2'd1, 8'(e));
        wr(2'd2, 8'(p));
        wr(2'd0, ctl(1, opm, 1, 1, 0, sel, 0));
        wait_edge(1'b0);
        wait_edge(1'b1);
        meas_run(1'b1, hi);
        meas_run(1'b0, lo);
        chk({req, " high time"}, hi, ((p - e) & 255) * d);
        chk({req, " period"}, hi + lo, t * d);
    endtask

    function automatic bit edge_ok(input int e, input int p);
        if (e == p || e < 0 || e > 255) return 1'b0;
        if (p < 252) return (e >= 252) || (e < p);
        return (e >= 252) && (e < p);
    endfunction

    task automatic watch_level(input string req, input int n, input logic lv);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out != lv) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        int plist[8] = '{3, 17, 60, 128, 251, 253, 254, 255};
        int hi, lo, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 period_flag", period_flag, 0);
        chk("R1 irq", irq, 0);
        watch_level("R1 idle after reset", 40, 1'b0);

        // R2 R3 R6 sweep of period limit and edge point at divide-by-2
        foreach (plist[i]) begin
            int p = plist[i];
            int cand[5] = '{252, 255, 0, p / 2, p - 1};
            foreach (cand[k]) begin
                if (edge_ok(cand[k], p)) run_cfg("R2 R3", cand[k], p, 0, 1'b0);
            end
        end

        // R6 other prescaler settings, including the slow one
        run_cfg("R6 div4", 10, 30, 1, 1'b0);
        run_cfg("R6 div8", 0, 5, 2, 1'b0);
        run_cfg("R6 div8000", 252, 253, 3, 1'b0);

        // R9 one-pulse bit set together with mode enable: waveform unchanged
        run_cfg("R9 priority", 20, 40, 0, 1'b1);

        // R5 double buffering: edge write during a high phase
        wr(2'd0, ctl(0, 0, 1, 1, 0, 0, 0));
        wr(2'd1, 8'd10);
        wr(2'd2, 8'd60);
        wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 0));
        wait_edge(1'b0);
        wait_edge(1'b1);
        fork
            wr(2'd1, 8'd40);
            meas_run(1'b1, hi);
        join
        chk("R5 running period keeps old edge", hi, 100);
        meas_run(1'b0, lo);
        meas_run(1'b1, hi);
        chk("R5 new edge after boundary", hi, 40);

        // R10 output enable clear: pin low while running, flag still set
        wr(2'd3, 8'd1);
        wr(2'd0, ctl(1, 0, 0, 1, 0, 0, 0));
        watch_level("R10 pin low with output disabled", 300, 1'b0);
        chk("R10 waveform still runs (flag)", period_flag, 1);

        // R4 equal levels give a constant high output
        wr(2'd0, ctl(0, 0, 1, 1, 1, 0, 0));
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd8);
        wr(2'd0, ctl(1, 0, 1, 1, 1, 0, 0));
        repeat (60) @(negedge clk);
        watch_level("R4 constant level", 200, 1'b1);

        // R3 edge point equal to period limit: period level wins
        wr(2'd0, ctl(0, 0, 1, 1, 0, 0, 0));
        wr(2'd1, 8'd8);
        wr(2'd2, 8'd8);
        wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 0));
        watch_level("R3 coincident match keeps period level", 200, 1'b0);

        // R9 R11 one-pulse bit alone: block stays off
        wr(2'd0, ctl(0, 1, 1, 1, 0, 0, 0));
        wr(2'd3, 8'd1);
        watch_level("R9 one-pulse alone leaves pin low", 200, 1'b0);
        chk("R9 one-pulse alone sets no flag", period_flag, 0);

        // R7 R8 flag and interrupt
        wr(2'd0, ctl(0, 0, 1, 1, 0, 0, 1));
        wr(2'd1, 8'd10);
        wr(2'd2, 8'd20);
        wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 1));
        wait_edge(1'b0);
        chk("R7 flag set at period end", period_flag, 1);
        chk("R8 irq with enable and no mask", irq, 1);
        glob_mask = 1'b1;
        @(negedge clk);
        chk("R8 irq blocked by mask", irq, 0);
        glob_mask = 1'b0;
        wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 0));
        chk("R8 irq off with enable clear", irq, 0);
        chk("R8 flag kept with enable clear", period_flag, 1);
        wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 1));

        // R7 clear, then a clear landing on the period-end edge
        d = 2 * (((20 - 252) & 255) + 1);
        wait_edge(1'b0);
        wr(2'd3, 8'd1);
        chk("R7 clear write", period_flag, 0);
        repeat (d - 3) @(negedge clk);
        chk("R7 flag low before boundary", period_flag, 0);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 boundary reached (pin fell)", pwm_out, 0);
        chk("R7 set wins over same-cycle clear", period_flag, 1);

        // R11 stop returns the pin low
        wr(2'd0, ctl(0, 0, 1, 1, 0, 0, 0));
        watch_level("R11 off state pin low", 50, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule